// File: doc/BRIEF.md
# External Interrupt Request Detector

This block watches six external interrupt request lines and one 4-bit encoded priority bus, and turns them into a single pending interrupt level for a processor. Each request line can be set to edge or level sensing. An edge line must stay high for at least two peripheral-clock samples before a request is latched. A latched request stays until software clears it or the processor acknowledges it. The encoded bus is inverted: the value 0000 asks for the top level, and 1111 asks for nothing.

Every request line carries a programmable 4-bit priority. The block picks the highest pending level and shows it on `intLevel`. It raises `intReq` when that level is strictly above a 4-bit mask held in a register. While the chip is in standby, any pending request line whose priority beats the mask drives `wake`. Software reaches the sense, request, priority and mask registers through a simple write strobe with a combinational read-back.

Top module: `extIrqDetect`

## Requirements
- R1: Bit i of the sense register (address 0) selects the mode of line i. 1 means rising-edge latched and 0 means level. Reset leaves every line in level mode.
- R2: An edge-mode line is latched only after it has been sampled high on two or more consecutive clock edges. A one-cycle pulse is ignored. A latched bit stays set after the line drops.
- R3: A level-mode line is pending only while it is held high. Nothing is latched, so dropping the line removes the request.
- R4: Reading address 1 returns the pending vector, one bit per line. Writing a 0 to bit i clears the latch of line i. Writing a 1 leaves it unchanged.
- R5: The encoded bus value v is a request at level 15 - v. A value of 15 is level 0, meaning no request.
- R6: The priority of line i sits in bits 4i+3:4i of address 2. `intLevel` is the highest level among the pending lines and the encoded bus. It is 0 when nothing is pending.
- R7: When levels tie, the lower line index wins. A request line wins a tie against the encoded bus.
- R8: `intReq` is 1 exactly when `intLevel` is strictly greater than the mask, which sits in bits 3:0 of address 3.
- R9: A one-cycle `ack` clears the latch of the winning edge-mode line only. A level-mode line stays pending. The mask is never altered by `ack`.
- R10: `wake` is 1 only while `standby` is 1 and some pending request line has a priority strictly greater than the mask. The encoded bus never causes a wake.
- R11: After reset, all registers read 0, and `intLevel`, `intReq` and `wake` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous reset, active high |
| irqPin | input | 6 | Request lines, active high, asynchronous |
| irlPin | input | 4 | Encoded priority bus, inverted, asynchronous |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 sense, 1 request, 2 priority, 3 mask |
| regWrData | input | 24 | Write data |
| regRdData | output | 24 | Read data for regAddr, combinational |
| ack | input | 1 | Processor accepted the current winner |
| standby | input | 1 | Chip is in standby |
| intLevel | output | 4 | Winning pending level |
| intReq | output | 1 | Interrupt request to the processor |
| wake | output | 1 | Standby wake request |

## Verification
The bench sweeps all sixteen bus codes and all sixteen mask values. An inverted decode, or a non-strict compare against the mask, would show a wrong level or a request at the boundary. Each line gets a one-cycle pulse and a two-cycle pulse. A filter that is too loose would latch the short pulse, and a filter that is too long would drop the valid one. Tied priorities are acknowledged one at a time. A reversed tie order would clear the higher index first, and an acknowledge that reached level-mode lines or the encoded bus would drop a request that should stay. The wake check uses a bus request above the mask and a request line exactly at the mask. Counting the bus, or using a non-strict compare, would wake the chip too early.

// File: rtl/extIrqPkg.sv
package extIrqPkg;
  localparam int IDX_W = 4;
  localparam logic [1:0] ADDR_SENSE = 2'd0;
  localparam logic [1:0] ADDR_REQ   = 2'd1;
  localparam logic [1:0] ADDR_PRIO  = 2'd2;
  localparam logic [1:0] ADDR_MASK  = 2'd3;

  typedef struct packed {
    logic             wrSense;
    logic             wrReq;
    logic             wrPrio;
    logic             wrMask;
    logic             ackHit;
    logic [IDX_W-1:0] ackIdx;
  } irqStrobe_t;
endpackage

// File: rtl/irqSync.sv
module irqSync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/extIrqDatapath.sv
module extIrqDatapath
  import extIrqPkg::*;
#(
  parameter int NUM_IRQ = 6,
  parameter int PRIO_W = 4,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD = 2,
  localparam int DATA_W = NUM_IRQ * PRIO_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_IRQ-1:0]  irqPin,
  input  logic [PRIO_W-1:0]   irlPin,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [1:0]          rdAddr,
  input  irqStrobe_t          strobe,
  output logic [DATA_W-1:0]   rdData,
  output logic [NUM_IRQ-1:0]  pend,
  output logic [DATA_W-1:0]   prioVec,
  output logic [PRIO_W-1:0]   maskVal,
  output logic [PRIO_W-1:0]   irlLevel
);
  localparam logic [HOLD-1:0] RUN_MASK = HOLD'((1 << (HOLD - 1)) - 1);

  logic [NUM_IRQ-1:0] syncd;
  logic [PRIO_W-1:0]  irlSyncd;
  logic [NUM_IRQ-1:0] qualVec;
  logic [NUM_IRQ-1:0] senseReg;
  logic [NUM_IRQ-1:0] latchReg;
  logic [NUM_IRQ-1:0] clrVec;
  logic [DATA_W-1:0]  prioReg;
  logic [PRIO_W-1:0]  maskReg;

  irqSync #(.W(NUM_IRQ), .STAGES(SYNC_STAGES), .RST_VAL('0)) uIrqSync (
    .clk(clk), .rst(rst), .d(irqPin), .q(syncd)
  );

  irqSync #(.W(PRIO_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) uIrlSync (
    .clk(clk), .rst(rst), .d(irlPin), .q(irlSyncd)
  );

  // per-line run-length filter: HOLD high samples preceded by a low one
  for (genvar g = 0; g < NUM_IRQ; g++) begin : gLine
    logic [HOLD-1:0] hist;
    always_ff @(posedge clk) begin
      if (rst) hist <= '0;
      else     hist <= (hist << 1) | HOLD'(syncd[g]);
    end
    assign qualVec[g] = syncd[g] && ((hist & RUN_MASK) == RUN_MASK) && !hist[HOLD-1];
  end

  always_comb begin
    clrVec = '0;
    if (strobe.wrReq) clrVec = ~wrData[NUM_IRQ-1:0];
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (strobe.ackHit && strobe.ackIdx == IDX_W'(i)) clrVec[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      senseReg <= '0;
      latchReg <= '0;
      prioReg  <= '0;
      maskReg  <= '0;
    end else begin
      if (strobe.wrSense) senseReg <= wrData[NUM_IRQ-1:0];
      if (strobe.wrPrio)  prioReg  <= wrData;
      if (strobe.wrMask)  maskReg  <= wrData[PRIO_W-1:0];
      latchReg <= (latchReg & ~clrVec) | (qualVec & senseReg);
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_IRQ; i++) pend[i] = senseReg[i] ? latchReg[i] : syncd[i];
  end

  assign prioVec  = prioReg;
  assign maskVal  = maskReg;
  assign irlLevel = ~irlSyncd;

  always_comb begin
    case (rdAddr)
      ADDR_SENSE: rdData = DATA_W'(senseReg);
      ADDR_REQ:   rdData = DATA_W'(pend);
      ADDR_PRIO:  rdData = prioReg;
      default:    rdData = DATA_W'(maskReg);
    endcase
  end
endmodule

// File: rtl/extIrqControl.sv
module extIrqControl
  import extIrqPkg::*;
#(
  parameter int NUM_IRQ = 6,
  parameter int PRIO_W = 4,
  localparam int DATA_W = NUM_IRQ * PRIO_W
) (
  input  logic               regWrEn,
  input  logic [1:0]         regAddr,
  input  logic               ack,
  input  logic               standby,
  input  logic [NUM_IRQ-1:0] pend,
  input  logic [DATA_W-1:0]  prioVec,
  input  logic [PRIO_W-1:0]  maskVal,
  input  logic [PRIO_W-1:0]  irlLevel,
  output irqStrobe_t         strobe,
  output logic [PRIO_W-1:0]  intLevel,
  output logic               intReq,
  output logic               wake
);
  logic [PRIO_W-1:0] best;
  logic [IDX_W-1:0]  bestIdx;
  logic              bestHit;
  logic              wakeAny;

  // highest level wins; scanning down with >= hands ties to the lower index
  // and lets any request line beat the encoded bus on equal level
  always_comb begin
    best    = irlLevel;
    bestIdx = '0;
    bestHit = 1'b0;
    wakeAny = 1'b0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (pend[i] && prioVec[i*PRIO_W +: PRIO_W] >= best) begin
        best    = prioVec[i*PRIO_W +: PRIO_W];
        bestIdx = IDX_W'(i);
        bestHit = 1'b1;
      end
      if (pend[i] && prioVec[i*PRIO_W +: PRIO_W] > maskVal) wakeAny = 1'b1;
    end
  end

  always_comb begin
    strobe.wrSense = regWrEn && regAddr == ADDR_SENSE;
    strobe.wrReq   = regWrEn && regAddr == ADDR_REQ;
    strobe.wrPrio  = regWrEn && regAddr == ADDR_PRIO;
    strobe.wrMask  = regWrEn && regAddr == ADDR_MASK;
    strobe.ackHit  = ack && bestHit;
    strobe.ackIdx  = bestIdx;
  end

  assign intLevel = best;
  assign intReq   = best > maskVal;
  assign wake     = standby && wakeAny;
endmodule

// File: rtl/extIrqDetect.sv
module extIrqDetect
  import extIrqPkg::*;
#(
  parameter int NUM_IRQ = 6,
  parameter int PRIO_W = 4,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD = 2,
  localparam int DATA_W = NUM_IRQ * PRIO_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irqPin,
  input  logic [PRIO_W-1:0]  irlPin,
  input  logic               regWrEn,
  input  logic [1:0]         regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic               ack,
  input  logic               standby,
  output logic [PRIO_W-1:0]  intLevel,
  output logic               intReq,
  output logic               wake
);
  irqStrobe_t         strobe;
  logic [NUM_IRQ-1:0] pend;
  logic [DATA_W-1:0]  prioVec;
  logic [PRIO_W-1:0]  maskVal;
  logic [PRIO_W-1:0]  irlLevel;

  extIrqDatapath #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .SYNC_STAGES(SYNC_STAGES), .HOLD(HOLD)) uDp (
    .clk(clk), .rst(rst), .irqPin(irqPin), .irlPin(irlPin),
    .wrData(regWrData), .rdAddr(regAddr), .strobe(strobe),
    .rdData(regRdData), .pend(pend), .prioVec(prioVec),
    .maskVal(maskVal), .irlLevel(irlLevel)
  );

  extIrqControl #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) uCtl (
    .regWrEn(regWrEn), .regAddr(regAddr), .ack(ack), .standby(standby),
    .pend(pend), .prioVec(prioVec), .maskVal(maskVal), .irlLevel(irlLevel),
    .strobe(strobe), .intLevel(intLevel), .intReq(intReq), .wake(wake)
  );
endmodule

// File: rtl/extIrqChecker.sv
module extIrqChecker #(
  parameter int PRIO_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              regWrEn,
  input logic [1:0]        regAddr,
  input logic              ack,
  input logic              standby,
  input logic [PRIO_W-1:0] intLevel,
  input logic              intReq,
  input logic              wake,
  input logic [PRIO_W-1:0] maskVal,
  input logic [PRIO_W-1:0] irlLevel
);
  assert_int_above_mask_R8: assert property (@(posedge clk) disable iff (rst)
    intReq |-> intLevel > maskVal);

  assert_irl_floor_R6: assert property (@(posedge clk) disable iff (rst)
    intLevel >= irlLevel);

  assert_mask_kept_R9: assert property (@(posedge clk) disable iff (rst)
    (ack && !(regWrEn && regAddr == 2'd3)) |=> $stable(maskVal));

  assert_wake_standby_R10: assert property (@(posedge clk) disable iff (rst)
    wake |-> standby);

  assert_wake_int_R10: assert property (@(posedge clk) disable iff (rst)
    wake |-> intReq);
endmodule

bind extIrqDetect extIrqChecker #(.PRIO_W(PRIO_W)) chk (
  .clk(clk), .rst(rst), .regWrEn(regWrEn), .regAddr(regAddr), .ack(ack),
  .standby(standby), .intLevel(intLevel), .intReq(intReq), .wake(wake),
  .maskVal(maskVal), .irlLevel(irlLevel)
);

// File: tb/tb_extIrqDetect.sv
module tb_extIrqDetect;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  irqPin = '0;
  logic [3:0]  irlPin = 4'hF;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [23:0] regWrData = '0;
  logic [23:0] regRdData;
  logic        ack = 1'b0;
  logic        standby = 1'b0;
  logic [3:0]  intLevel;
  logic        intReq;
  logic        wake;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  extIrqDetect dut (
    .clk(clk), .rst(rst), .irqPin(irqPin), .irlPin(irlPin),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .ack(ack), .standby(standby),
    .intLevel(intLevel), .intReq(intReq), .wake(wake)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [23:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [23:0] v);
    regAddr = a;
    #1 v = regRdData;
  endtask

  task automatic pulse(input logic [5:0] m, input int n);
    @(negedge clk);
    irqPin = irqPin | m;
    repeat (n) @(negedge clk);
    irqPin = irqPin & ~m;
  endtask

  task automatic doAck();
    @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [23:0] v;
    tick(3);
    rst = 1'b0;
    tick(1);

    // R11: reset state
    check("R11 intLevel", 32'(intLevel), 0);
    check("R11 intReq", 32'(intReq), 0);
    check("R11 wake", 32'(wake), 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check("R11 register", 32'(v), 0);
    end

    // R5, R8: full sweep of the encoded bus with mask 0
    for (int c = 0; c < 16; c++) begin
      irlPin = 4'(c);
      tick(4);
      check("R5 bus level", 32'(intLevel), 32'(15 - c));
      check("R8 bus request", 32'(intReq), 32'((15 - c) > 0));
    end

    // R8: mask sweep against bus level 9
    irlPin = 4'd6;
    for (int m = 0; m < 16; m++) begin
      wr(2'd3, 24'(m));
      tick(1);
      check("R8 mask compare", 32'(intReq), 32'(9 > m));
    end
    wr(2'd3, 24'd0);
    irlPin = 4'hF;
    tick(4);

    // R3: level mode, priorities i+1
    wr(2'd2, 24'h654321);
    for (int i = 0; i < 6; i++) begin
      irqPin[i] = 1'b1;
      tick(4);
      check("R3 level pending", 32'(intLevel), 32'(i + 1));
      rd(2'd1, v);
      check("R3 level request bit", 32'(v), 32'(1 << i));
      irqPin[i] = 1'b0;
      tick(4);
      check("R3 level released", 32'(intLevel), 0);
    end

    // R2, R4: edge mode filter and latching
    wr(2'd0, 24'h3F);
    for (int i = 0; i < 6; i++) begin
      pulse(6'(1 << i), 1);
      tick(6);
      rd(2'd1, v);
      check("R2 short pulse ignored", 32'(v), 0);
      pulse(6'(1 << i), 2);
      tick(6);
      rd(2'd1, v);
      check("R2 two-cycle pulse latched", 32'(v), 32'(1 << i));
      check("R2 latched level", 32'(intLevel), 32'(i + 1));
      wr(2'd1, 24'(6'h3F & ~(6'(1 << i))));
      rd(2'd1, v);
      check("R4 write zero clears", 32'(v), 0);
    end

    // R4: write one keeps
    pulse(6'h0A, 3);
    tick(6);
    wr(2'd1, 24'h08);
    rd(2'd1, v);
    check("R4 write one keeps", 32'(v), 32'h08);
    wr(2'd1, 24'h0);

    // R1: only line 0 in edge mode
    wr(2'd0, 24'h01);
    pulse(6'h3F, 2);
    tick(6);
    rd(2'd1, v);
    check("R1 mixed sense", 32'(v), 32'h01);
    rd(2'd0, v);
    check("R1 sense readback", 32'(v), 32'h01);
    wr(2'd1, 24'h0);
    wr(2'd0, 24'h3F);

    // R6, R9: highest wins, ack clears winner
    pulse(6'h21, 2);
    tick(6);
    check("R6 highest level", 32'(intLevel), 6);
    doAck();
    rd(2'd1, v);
    check("R9 ack clears winner", 32'(v), 32'h01);
    check("R6 next level", 32'(intLevel), 1);
    doAck();
    rd(2'd1, v);
    check("R9 second ack", 32'(v), 0);

    // R7: ties between lines go to lower index
    wr(2'd2, 24'h555555);
    pulse(6'h14, 2);
    tick(6);
    check("R7 tie level", 32'(intLevel), 5);
    doAck();
    rd(2'd1, v);
    check("R7 lower index taken first", 32'(v), 32'h10);
    doAck();
    rd(2'd1, v);
    check("R7 higher index after", 32'(v), 0);

    // R7: line beats bus on tie
    irlPin = 4'd10;
    pulse(6'h08, 2);
    tick(6);
    check("R7 tie with bus", 32'(intLevel), 5);
    doAck();
    rd(2'd1, v);
    check("R7 line wins over bus", 32'(v), 0);
    check("R7 bus remains", 32'(intLevel), 5);
    irlPin = 4'hF;
    tick(4);

    // R9: level line survives ack, mask unchanged
    wr(2'd0, 24'h0);
    wr(2'd2, 24'h000070);
    wr(2'd3, 24'h3);
    irqPin[1] = 1'b1;
    tick(4);
    doAck();
    rd(2'd1, v);
    check("R9 level line kept", 32'(v), 32'h02);
    check("R9 level still wins", 32'(intLevel), 7);
    rd(2'd3, v);
    check("R9 mask kept", 32'(v), 3);
    irqPin[1] = 1'b0;
    tick(4);

    // R10: wake
    wr(2'd3, 24'h4);
    standby = 1'b1;
    irlPin = 4'd0;
    tick(4);
    check("R10 bus no wake", 32'(wake), 0);
    check("R8 bus request in standby", 32'(intReq), 1);
    irlPin = 4'hF;
    wr(2'd2, 24'h000004);
    irqPin[0] = 1'b1;
    tick(4);
    check("R10 equal to mask no wake", 32'(wake), 0);
    wr(2'd2, 24'h000005);
    tick(1);
    check("R10 above mask wakes", 32'(wake), 1);
    standby = 1'b0;
    #1;
    check("R10 no standby no wake", 32'(wake), 0);
    irqPin[0] = 1'b0;
    tick(4);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule